// File: doc/BRIEF.md
# Pipeline Interlock and Bank-Conflict Stall Unit

This unit decides, cycle by cycle, whether the front (setup) half and the back (execute) half of a seven-stage pipeline may advance. It watches the instruction sitting in decode and keeps its own record of the four execute-side stages behind it (EX, D1, D2, DW). Three kinds of hazard are resolved in hardware. A consumer that reads a register still being loaded is held. Memory operations that hit the same interleaved data-cache bank too soon after each other are held. Register-file writes that collide with the single write port are pushed back by one slot.

The two halves stall independently. The setup half holds its instruction whenever there is a dependency, an instruction-side miss or bank clash, or a stall in the execute half. The execute half freezes only on a data-cache miss or a data-bank clash. While the setup half waits and the execute half runs, empty slots (bubbles) enter EX, so that a pending load can finish and release its consumer. Loaded data is parked in a one-entry holding register that drains into free write slots. Cache and register-file storage lie outside this unit.

Top module: `pipe_hazard_unit`

## Requirements
- R1: Instruction classes use `decClass` encoding 0 = no register write, 1 = ALU (writes a register), 2 = LOAD, 3 = STORE. When a valid decode instruction has a nonzero source equal to the destination of a valid LOAD in EX, D1 or D2, `setupStall` is high. A consumer presented g cycles after the LOAD (g = 0..3) therefore waits max(0, 3 - g) cycles.
- R2: Register number 0 used as a source never raises a dependency stall.
- R3: In any cycle where the setup half is stalled and the execute half is not, `bubbleInsert` is high, an empty slot enters EX, and the decode instruction is held.
- R4: The execute stages advance one place per cycle unless `execStall` is high. While it is high, every execute stage holds its contents and `setupStall` is also high, so a load stalled by a data miss extends its consumer's wait by the miss length.
- R5: `decBank` is one bit selecting one of two data banks. After a memory operation leaves EX, a later memory operation to the same bank that reaches EX g cycles later waits max(0, N - g) cycles with `execStall` high, where N = 1 after a LOAD and N = 2 after a STORE. Different banks never wait.
- R6: `dcMiss` raises `execStall` and `setupStall` in the same cycle, for as many cycles as it is held.
- R7: `icMiss` or `icBankBusy` raises `setupStall` but not `execStall`, and the execute half keeps moving during it.
- R8: When an ALU instruction is in DW while a STORE is in D2, `regWriteDefer` is high in that cycle.
- R9: When two LOADs occupy DW in consecutive cycles, the still-parked value claims the next write slot, and an ALU instruction reaching DW in that next cycle is deferred. With a gap before the second LOAD, the holding register drains first and nothing is deferred.
- R10: An ALU instruction arriving in DW in the cycle after a deferral is also deferred. The chain ends at the first DW slot without an ALU instruction.
- R11: After reset all four outputs are low and the execute stages are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decode stage holds an instruction |
| decClass | input | 2 | Instruction class (0 none, 1 ALU, 2 LOAD, 3 STORE) |
| decDest | input | REG_W | Destination register number |
| decSrcA | input | REG_W | First source register number |
| decSrcB | input | REG_W | Second source register number |
| decBank | input | BANK_W | Data-cache bank of a memory operation |
| icMiss | input | 1 | Instruction-cache miss |
| icBankBusy | input | 1 | Instruction-cache bank contention |
| dcMiss | input | 1 | Data-cache miss |
| setupStall | output | 1 | Hold the setup half (fetch and decode) |
| execStall | output | 1 | Freeze the execute half |
| bubbleInsert | output | 1 | An empty slot enters EX this cycle |
| regWriteDefer | output | 1 | The DW instruction's register write moves to the next slot |

## Verification
The hardest situation to reach is the forced drain of the holding register. It needs two LOADs to reach DW in back-to-back cycles, followed at once by a run of ALU instructions. A same-bank pair would be pulled apart by the bank interlock, so the stimulus places the two LOADs on different banks and gives every ALU instruction a zero source to avoid the load shadow. The expected number of deferred slots then follows directly from the chain rule. Bank recovery and the load shadow are swept over every operation pair, both bank relations and every gap, and each expected stall count is taken from the max(0, N - g) formulas.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ALU   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } opClass_t;

  // strobes from control to the execute-stage datapath
  typedef struct packed {
    logic advance;  // execute stages shift this cycle
    logic bubble;   // EX receives an empty slot instead of decode
  } hzdStrobe_t;

  function automatic logic isMem(opClass_t c);
    return (c == OP_LOAD) || (c == OP_STORE);
  endfunction

endpackage

// File: rtl/hzd_pipe.sv
module hzd_pipe
  import hzd_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int BANK_W    = 1,
  parameter int LOAD_GAP  = 1,
  parameter int STORE_GAP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  opClass_t          decClass,
  input  logic [REG_W-1:0]  decDest,
  input  logic [REG_W-1:0]  decSrcA,
  input  logic [REG_W-1:0]  decSrcB,
  input  logic [BANK_W-1:0] decBank,
  input  hzdStrobe_t        strobe,
  output logic              useHit,
  output logic              bankHit,
  output logic              dwAlu,
  output logic              dwLoad,
  output logic              d2Store
);

  localparam int NSTG   = 4;          // EX, D1, D2, DW
  localparam int SHADOW = NSTG - 1;   // stages before the load result lands
  localparam int NBANK  = 1 << BANK_W;
  localparam int MAXGAP = (STORE_GAP > LOAD_GAP) ? STORE_GAP : LOAD_GAP;
  localparam int CNT_W  = $clog2(MAXGAP + 1);

  typedef struct packed {
    logic              valid;
    opClass_t          cls;
    logic [REG_W-1:0]  dest;
    logic [BANK_W-1:0] bank;
  } stage_t;

  stage_t decRec;
  stage_t stg [NSTG];

  assign decRec = '{valid: decValid, cls: decClass, dest: decDest, bank: decBank};

  // execute-side stage records
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stg[0] <= '0;
    else if (strobe.advance) stg[0] <= strobe.bubble ? '0 : decRec;
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stg[i] <= '0;
      else if (strobe.advance) stg[i] <= stg[i-1];
    end
  end

  // load shadow compare
  logic [SHADOW-1:0] shadowHit;
  for (genvar i = 0; i < SHADOW; i++) begin : g_shadow
    assign shadowHit[i] = stg[i].valid && (stg[i].cls == OP_LOAD) &&
                          (((decSrcA != '0) && (decSrcA == stg[i].dest)) ||
                           ((decSrcB != '0) && (decSrcB == stg[i].dest)));
  end
  assign useHit = decValid && (|shadowHit);

  // bank recovery counters
  logic             exMem;
  logic [CNT_W-1:0] exRec;
  logic [CNT_W-1:0] bankCnt [NBANK];

  assign exMem = stg[0].valid && isMem(stg[0].cls);
  assign exRec = (stg[0].cls == OP_STORE) ? CNT_W'(STORE_GAP) : CNT_W'(LOAD_GAP);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankCnt[b] <= '0;
      else if (strobe.advance && exMem && (stg[0].bank == BANK_W'(b)))
        bankCnt[b] <= exRec;
      else if (bankCnt[b] != '0)
        bankCnt[b] <= bankCnt[b] - 1'b1;
    end
  end

  assign bankHit = exMem && (bankCnt[stg[0].bank] != '0);

  // write-port view
  assign dwAlu   = stg[NSTG-1].valid && (stg[NSTG-1].cls == OP_ALU);
  assign dwLoad  = stg[NSTG-1].valid && (stg[NSTG-1].cls == OP_LOAD);
  assign d2Store = stg[NSTG-2].valid && (stg[NSTG-2].cls == OP_STORE);

  // assertions
  AST_LOAD_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.bubble && decValid && decClass == OP_LOAD && decDest != '0)
    |=> (!(decValid && decSrcA == $past(decDest)) || useHit)); // R1

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decSrcA == '0 && decSrcB == '0) |-> !useHit); // R2

  AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.bubble) |=> !stg[0].valid); // R3

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(stg[0]) && $stable(stg[NSTG-1]))); // R4

  AST_STORE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && stg[0].valid && stg[0].cls == OP_STORE)
    |=> (!(exMem && stg[0].bank == $past(stg[0].bank)) || bankHit)); // R5

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       useHit,
  input  logic       bankHit,
  input  logic       dwAlu,
  input  logic       dwLoad,
  input  logic       d2Store,
  input  logic       icMiss,
  input  logic       icBankBusy,
  input  logic       dcMiss,
  output hzdStrobe_t strobe,
  output logic       setupStall,
  output logic       execStall,
  output logic       bubbleInsert,
  output logic       regWriteDefer
);

  logic holdFull;    // holding register has parked load data
  logic forceDrain;  // parked value claims this write slot
  logic deferPend;   // a deferred write claims this write slot
  logic deferNow;
  logic slotFree;

  assign execStall    = dcMiss || bankHit;
  assign setupStall   = useHit || icMiss || icBankBusy || execStall;
  assign bubbleInsert = setupStall && !execStall;

  assign strobe.advance = !execStall;
  assign strobe.bubble  = setupStall;

  assign deferNow      = dwAlu && (d2Store || forceDrain || deferPend);
  assign regWriteDefer = deferNow && !execStall;

  // slot unused by a deferred write, a forced drain, the arriving load or a live ALU write
  assign slotFree = !deferPend && !forceDrain && !dwLoad && !(dwAlu && !deferNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull   <= 1'b0;
      forceDrain <= 1'b0;
      deferPend  <= 1'b0;
    end else if (strobe.advance) begin
      deferPend  <= deferNow;
      forceDrain <= dwLoad && holdFull;
      holdFull   <= dwLoad || (holdFull && !slotFree);
    end
  end

  AST_HOLD_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (dwAlu && !execStall && $past(dwLoad && !execStall) && $past(dwLoad && !execStall, 2))
    |-> regWriteDefer); // R9

  AST_DEFER_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    regWriteDefer |=> (!dwAlu || execStall || regWriteDefer)); // R10

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int BANK_W    = 1,
  parameter int LOAD_GAP  = 1,
  parameter int STORE_GAP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [1:0]        decClass,
  input  logic [REG_W-1:0]  decDest,
  input  logic [REG_W-1:0]  decSrcA,
  input  logic [REG_W-1:0]  decSrcB,
  input  logic [BANK_W-1:0] decBank,
  input  logic              icMiss,
  input  logic              icBankBusy,
  input  logic              dcMiss,
  output logic              setupStall,
  output logic              execStall,
  output logic              bubbleInsert,
  output logic              regWriteDefer
);

  hzdStrobe_t strobe;
  logic useHit, bankHit, dwAlu, dwLoad, d2Store;

  hzd_pipe #(
    .REG_W(REG_W), .BANK_W(BANK_W), .LOAD_GAP(LOAD_GAP), .STORE_GAP(STORE_GAP)
  ) u_pipe (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decClass(opClass_t'(decClass)),
    .decDest(decDest), .decSrcA(decSrcA), .decSrcB(decSrcB), .decBank(decBank),
    .strobe(strobe),
    .useHit(useHit), .bankHit(bankHit),
    .dwAlu(dwAlu), .dwLoad(dwLoad), .d2Store(d2Store)
  );

  hzd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .useHit(useHit), .bankHit(bankHit),
    .dwAlu(dwAlu), .dwLoad(dwLoad), .d2Store(d2Store),
    .icMiss(icMiss), .icBankBusy(icBankBusy), .dcMiss(dcMiss),
    .strobe(strobe),
    .setupStall(setupStall), .execStall(execStall),
    .bubbleInsert(bubbleInsert), .regWriteDefer(regWriteDefer)
  );

endmodule

// File: tb/sim_pipe_hazard_unit.sv
`timescale 1ns/1ps
module sim_pipe_hazard_unit;

  localparam logic [1:0] C_NONE = 2'd0, C_ALU = 2'd1, C_LOAD = 2'd2, C_STORE = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [1:0] decClass = 2'd0;
  logic [4:0] decDest = '0, decSrcA = '0, decSrcB = '0;
  logic [0:0] decBank = '0;
  logic icMiss = 1'b0, icBankBusy = 1'b0, dcMiss = 1'b0;
  logic setupStall, execStall, bubbleInsert, regWriteDefer;

  int errors = 0, checks = 0;
  int cntS = 0, cntE = 0, cntB = 0, cntD = 0;

  always #5 clk = ~clk;

  pipe_hazard_unit u0 (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decClass(decClass),
    .decDest(decDest), .decSrcA(decSrcA), .decSrcB(decSrcB), .decBank(decBank),
    .icMiss(icMiss), .icBankBusy(icBankBusy), .dcMiss(dcMiss),
    .setupStall(setupStall), .execStall(execStall),
    .bubbleInsert(bubbleInsert), .regWriteDefer(regWriteDefer)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic zero();
    cntS = 0; cntE = 0; cntB = 0; cntD = 0;
  endtask

  // called just after a falling edge; samples then waits for the next falling edge
  task automatic tick(output logic st);
    #2;
    st = setupStall;
    cntS += int'(setupStall);
    cntE += int'(execStall);
    cntB += int'(bubbleInsert);
    cntD += int'(regWriteDefer);
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    logic st;
    decValid = 1'b0;
    for (int k = 0; k < n; k++) tick(st);
  endtask

  task automatic issue(input logic [1:0] c, input int d, input int a, input int b,
                       input int bk, input int miss);
    logic st;
    decValid = 1'b1; decClass = c; decDest = 5'(d);
    decSrcA = 5'(a); decSrcB = 5'(b); decBank = 1'(bk);
    for (int k = 0; k < miss; k++) begin
      dcMiss = 1'b1;
      tick(st);
    end
    dcMiss = 1'b0;
    do tick(st); while (st);
    decValid = 1'b0; decSrcA = '0; decSrcB = '0; decClass = C_NONE;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #2;
    chk("R11 setupStall", int'(setupStall), 0);
    chk("R11 execStall", int'(execStall), 0);
    chk("R11 bubbleInsert", int'(bubbleInsert), 0);
    chk("R11 regWriteDefer", int'(regWriteDefer), 0);
    @(negedge clk);
    rstN = 1'b1;
    nop(2);
    #2;
    chk("R11 setupStall after release", int'(setupStall), 0);
    @(negedge clk);

    // R5: bank recovery sweep
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 2; s++)
        for (int same = 0; same < 2; same++)
          for (int g = 0; g < 3; g++) begin
            int rec, exp;
            rec = (f == 1) ? 2 : 1;
            exp = (same == 1) ? ((rec - g > 0) ? rec - g : 0) : 0;
            nop(8); zero();
            issue((f == 1) ? C_STORE : C_LOAD, 7, 0, 0, 0, 0);
            nop(g);
            issue((s == 1) ? C_STORE : C_LOAD, 7, 0, 0, (same == 1) ? 0 : 1, 0);
            nop(8);
            chk($sformatf("R5 f=%0d s=%0d same=%0d g=%0d", f, s, same, g), cntE, exp);
          end

    // R1 and R3: load shadow sweep
    for (int which = 0; which < 2; which++)
      for (int g = 0; g < 4; g++) begin
        int exp;
        exp = 3 - g;
        nop(8);
        issue(C_LOAD, 9, 0, 0, 0, 0);
        nop(g);
        zero();
        issue(C_ALU, 3, (which == 0) ? 9 : 0, (which == 1) ? 9 : 0, 0, 0);
        chk($sformatf("R1 src%0d g=%0d", which, g), cntS, exp);
        chk($sformatf("R3 bubbles src%0d g=%0d", which, g), cntB, exp);
      end

    // R2: register 0 never stalls
    nop(8);
    issue(C_LOAD, 0, 0, 0, 0, 0);
    zero();
    issue(C_ALU, 3, 0, 0, 0, 0);
    chk("R2 zero source", cntS, 0);

    // R1: non-matching source
    nop(8);
    issue(C_LOAD, 9, 0, 0, 0, 0);
    zero();
    issue(C_ALU, 3, 10, 11, 0, 0);
    chk("R1 no match", cntS, 0);

    // R4 and R6: data miss while a load sits in EX
    nop(8);
    issue(C_LOAD, 9, 0, 0, 0, 0);
    zero();
    issue(C_ALU, 3, 9, 0, 0, 2);
    chk("R4 stretched shadow", cntS, 5);
    chk("R6 exec stall cycles", cntE, 2);
    chk("R3 bubbles only when exec runs", cntB, 3);

    // R6: data miss alone
    nop(8); zero();
    dcMiss = 1'b1;
    nop(3);
    dcMiss = 1'b0;
    chk("R6 execStall", cntE, 3);
    chk("R6 setupStall", cntS, 3);

    // R7: instruction miss lets execute run
    nop(8);
    issue(C_LOAD, 4, 0, 0, 0, 0);
    zero();
    icMiss = 1'b1;
    nop(2);
    icMiss = 1'b0;
    chk("R7 setupStall on icMiss", cntS, 2);
    chk("R7 no execStall on icMiss", cntE, 0);
    zero();
    issue(C_ALU, 3, 4, 0, 0, 0);
    chk("R7 load advanced during icMiss", cntS, 1);
    nop(8); zero();
    icBankBusy = 1'b1;
    nop(1);
    icBankBusy = 1'b0;
    chk("R7 setupStall on icBankBusy", cntS, 1);
    chk("R7 no execStall on icBankBusy", cntE, 0);

    // R8: store behind ALU
    nop(8); zero();
    issue(C_ALU, 3, 0, 0, 0, 0);
    issue(C_STORE, 0, 0, 0, 0, 0);
    nop(8);
    chk("R8 ALU then STORE", cntD, 1);
    nop(8); zero();
    issue(C_ALU, 3, 0, 0, 0, 0);
    nop(1);
    issue(C_STORE, 0, 0, 0, 0, 0);
    nop(8);
    chk("R8 gap before STORE", cntD, 0);

    // R9: parked data claims the slot
    nop(8); zero();
    issue(C_LOAD, 5, 0, 0, 0, 0);
    issue(C_LOAD, 6, 0, 0, 1, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    nop(8);
    chk("R9 LOAD LOAD ALU", cntD, 1);
    nop(8); zero();
    issue(C_LOAD, 5, 0, 0, 0, 0);
    nop(1);
    issue(C_LOAD, 6, 0, 0, 1, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    nop(8);
    chk("R9 drained before second LOAD", cntD, 0);

    // R10: deferral chain
    nop(8); zero();
    issue(C_LOAD, 5, 0, 0, 0, 0);
    issue(C_LOAD, 6, 0, 0, 1, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    nop(8);
    chk("R10 chain of three", cntD, 3);
    nop(8); zero();
    issue(C_ALU, 3, 0, 0, 0, 0);
    issue(C_STORE, 0, 0, 0, 0, 0);
    issue(C_ALU, 3, 0, 0, 0, 0);
    nop(8);
    chk("R10 chain ends at STORE slot", cntD, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule